// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus that a switch or MAC uses to read and write registers inside Ethernet PHYs. Software programs it through five 64-bit registers: one for the command, one for write data, one for read data, one for clock and framing setup, and one for enable. Writing the command register starts exactly one serial frame on MDC/MDIO. Software then polls the pending flag in the matching data register until the frame is done.

The framing style is chosen globally by a mode bit in the clock register, not per command. With the bit clear, frames use the Clause 22 layout. With it set, frames use the Clause 45 layout, and the same 2-bit command op selects an address, write or read cycle. A Clause 45 access is therefore two commands: an address cycle that carries a 16-bit register number from the write-data register, then the write or read. The MDC rate comes from a programmable divider. MDIO changes after each falling MDC edge and is sampled on each rising edge. On reads the master releases the line from the turnaround onward, and it judges the response good only if the PHY pulls the second turnaround bit low.

Top module: `mdio_master`

## Requirements
- R1: The registers decode at byte offsets 0x00 (command), 0x08 (write data), 0x10 (read data), 0x18 (clock setup) and 0x20 (enable). Any other offset reads zero, and register bits with no field read zero. The clock setup register holds divider [7:0], sample [11:8], preamble enable 12, idle level 13, sample mode 15, sample high [20:16] and frame mode 24, so writing all ones reads back 0x11FBFFF.
- R2: After reset every register reads zero, MDC is low and the MDIO output enable is low.
- R3: While enable bit 0 is clear, a command write starts no frame, sets no pending flag, and MDC holds its idle level.
- R4: While a frame runs, MDC toggles every divider+1 system clocks, so consecutive driven bits are 2×(divider+1) clocks apart. When no frame runs, MDC rests at the idle-level bit.
- R5: With frame mode 0, the command register's op [17:16] value 0 sends a write and value 1 sends a read. The frame starts with 01, followed by wire opcode 01 for a write or 10 for a read, then the port address (command [12:8]) and register address (command [4:0]), MSB first.
- R6: With frame mode 1, the start code is 00. Command op 0 sends an address cycle with wire opcode 00 and the write-data field as its 16 data bits, op 1 sends a write (01) and op 3 sends a read (11).
- R7: With preamble enable set, 32 one-bits precede the start code. With it clear, none are sent.
- R8: A write or address frame drives turnaround 10 and then the 16 data bits, MSB first. Write-data pending (bit 17) is set from the command until the last bit, and valid (bit 16) is then set.
- R9: A read frame releases MDIO (output enable low) from the first turnaround bit onward. It shifts in 16 sampled bits MSB first into read-data [15:0], holds read-data pending (bit 17) for the frame, and sets valid (bit 16) when the second turnaround bit was sampled low.
- R10: If the second turnaround bit of a read is sampled high, the read completes with valid clear.
- R11: A command written while either pending flag is set is ignored: the running frame completes unchanged and no second frame follows.
- R12: Op value 2 or 3 in frame mode 0, and op value 2 in frame mode 1, start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data for csr_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest state to reach from the ports is a read whose turnaround goes wrong. Reaching it needs a PHY that responds on exact MDC falling edges after the master lets go of the line. The bench models such a PHY: it counts falling MDC edges with the output enable low, and on each one drives the chosen turnaround bit and then the response word, so a missing turnaround can be forced on purpose. A second hard case is the collision between a new command and a frame in progress. The bench reaches it by writing a read command on the cycle after a write was accepted, then watching that only the original frame ever appears on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN  = 32;
    localparam int ADR_W    = 5;
    localparam int DATA_W   = 16;
    localparam int HDR_W    = 2 + 2 + ADR_W + ADR_W;
    localparam int FRAME_W  = HDR_W + 2 + DATA_W;
    localparam int SEQ_W    = PRE_LEN + FRAME_W;
    localparam int IDX_W    = $clog2(SEQ_W);
    localparam int FR_IW    = $clog2(FRAME_W);
    localparam int DIV_W    = 8;
    localparam int CSR_W    = 64;
    localparam int CSR_AW   = 6;

    localparam logic [CSR_AW-1:0] OFS_CMD  = 6'h00;
    localparam logic [CSR_AW-1:0] OFS_WDAT = 6'h08;
    localparam logic [CSR_AW-1:0] OFS_RDAT = 6'h10;
    localparam logic [CSR_AW-1:0] OFS_CFG  = 6'h18;
    localparam logic [CSR_AW-1:0] OFS_EN   = 6'h20;

    localparam int CMD_DEV_LSB  = 0;
    localparam int CMD_PHY_LSB  = 8;
    localparam int CMD_OP_LSB   = 16;
    localparam int DAT_VAL_BIT  = 16;
    localparam int DAT_PEND_BIT = 17;
    localparam int CFG_SMP_LSB  = 8;
    localparam int CFG_PRE_BIT  = 12;
    localparam int CFG_IDLE_BIT = 13;
    localparam int CFG_SMOD_BIT = 15;
    localparam int CFG_SHI_LSB  = 16;
    localparam int CFG_MODE_BIT = 24;

    typedef struct packed {
        logic [1:0]        st;
        logic [1:0]        op;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  dev;
        logic [DATA_W-1:0] data;
        logic              rd;
        logic              pre;
    } xact_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             idle_i,
    input  logic [DIV_W-1:0] phase_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == phase_i);
        if (!run_i) begin
            s_d.cnt = '0;
            s_d.mdc = idle_i;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_o  = s_q.mdc;
    assign rise_o = run_i && wrap && !s_q.mdc;
    assign fall_o = run_i && wrap &&  s_q.mdc;

    // R3 / R4: a stopped divider parks the clock at the idle level
    a_r3_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (mdc_o == $past(idle_i)));

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  xact_t             xact_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ta_ok_o
);

    localparam logic [IDX_W-1:0] IDX_FRAME = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(PRE_LEN + HDR_W);
    localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(PRE_LEN + HDR_W + 1);
    localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(PRE_LEN + HDR_W + 2);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SEQ_W - 1);
    localparam logic [FR_IW-1:0] FR_TOP    = FR_IW'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic               armed;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
        logic               rd;
        logic               oe;
        logic               dout;
        logic [DATA_W-1:0]  rdata;
        logic               ta_ok;
    } eng_t;

    eng_t s_d, s_q;
    logic done_d;
    logic next_bit;

    always_comb begin
        s_d      = s_q;
        done_d   = 1'b0;
        next_bit = (s_q.idx < IDX_FRAME) ? 1'b1
                 : s_q.frame[FR_TOP - s_q.idx[FR_IW-1:0]];
        if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.armed = 1'b0;
            s_d.idx   = xact_i.pre ? '0 : IDX_FRAME;
            s_d.frame = {xact_i.st, xact_i.op, xact_i.phy, xact_i.dev,
                         2'b10, xact_i.data};
            s_d.rd    = xact_i.rd;
            s_d.oe    = 1'b0;
            s_d.dout  = 1'b1;
            s_d.rdata = '0;
            s_d.ta_ok = 1'b0;
        end else if (s_q.busy) begin
            if (fall_i) begin
                s_d.armed = 1'b1;
                s_d.dout  = next_bit;
                s_d.oe    = !(s_q.rd && (s_q.idx >= IDX_TA1));
            end
            if (rise_i && s_q.armed) begin
                if (s_q.rd && (s_q.idx == IDX_TA2)) begin
                    s_d.ta_ok = !mdio_i;
                end
                if (s_q.rd && (s_q.idx >= IDX_DATA)) begin
                    s_d.rdata = {s_q.rdata[DATA_W-2:0], mdio_i};
                end
                if (s_q.idx == IDX_LAST) begin
                    done_d    = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.armed = 1'b0;
                    s_d.oe    = 1'b0;
                    s_d.dout  = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign mdio_o    = s_q.dout;
    assign mdio_oe_o = s_q.oe;
    assign done_o    = done_d;
    assign rdata_o   = s_d.rdata;
    assign ta_ok_o   = s_d.ta_ok;

    // R4 / R8: the line is only taken on a falling management clock edge
    a_r8_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> $past(fall_i));

    // R11: the register bank never launches into a running frame
    a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              ta_ok_i,
    output logic              start_o,
    output xact_t             xact_o,
    output logic              en_o,
    output logic              idle_o,
    output logic [DIV_W-1:0]  phase_o
);

    typedef struct packed {
        logic [1:0]        op;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  dev;
        logic [DATA_W-1:0] wdat;
        logic              wval;
        logic              wpend;
        logic [DATA_W-1:0] rdat;
        logic              rval;
        logic              rpend;
        logic [DIV_W-1:0]  phase;
        logic [3:0]        smp;
        logic              pre;
        logic              idle;
        logic              smode;
        logic [4:0]        shi;
        logic              c45;
        logic              en;
    } regs_t;

    regs_t r_d, r_q;

    logic             hit_cmd, hit_wdat, hit_cfg, hit_en;
    logic [1:0]       cmd_op;
    logic             op_ok, is_rd, accept;
    logic             unused_bits;

    assign hit_cmd  = csr_wr && (csr_addr == OFS_CMD);
    assign hit_wdat = csr_wr && (csr_addr == OFS_WDAT);
    assign hit_cfg  = csr_wr && (csr_addr == OFS_CFG);
    assign hit_en   = csr_wr && (csr_addr == OFS_EN);
    assign cmd_op   = csr_wdata[CMD_OP_LSB +: 2];
    assign op_ok    = r_q.c45 ? (cmd_op != 2'd2) : !cmd_op[1];
    assign is_rd    = r_q.c45 ? (cmd_op == 2'd3) : (cmd_op == 2'd1);
    assign accept   = hit_cmd && r_q.en && !r_q.wpend && !r_q.rpend && op_ok;
    assign unused_bits = ^{csr_wdata[CSR_W-1:25], csr_wdata[14]};

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.op  = cmd_op;
            r_d.phy = csr_wdata[CMD_PHY_LSB +: ADR_W];
            r_d.dev = csr_wdata[CMD_DEV_LSB +: ADR_W];
            if (is_rd) begin
                r_d.rpend = 1'b1;
                r_d.rval  = 1'b0;
            end else begin
                r_d.wpend = 1'b1;
                r_d.wval  = 1'b0;
            end
        end
        if (done_i) begin
            if (r_q.rpend) begin
                r_d.rpend = 1'b0;
                r_d.rval  = ta_ok_i;
                r_d.rdat  = rdata_i;
            end else begin
                r_d.wpend = 1'b0;
                r_d.wval  = 1'b1;
            end
        end
        if (hit_wdat) r_d.wdat = csr_wdata[DATA_W-1:0];
        if (hit_cfg) begin
            r_d.phase = csr_wdata[DIV_W-1:0];
            r_d.smp   = csr_wdata[CFG_SMP_LSB +: 4];
            r_d.pre   = csr_wdata[CFG_PRE_BIT];
            r_d.idle  = csr_wdata[CFG_IDLE_BIT];
            r_d.smode = csr_wdata[CFG_SMOD_BIT];
            r_d.shi   = csr_wdata[CFG_SHI_LSB +: 5];
            r_d.c45   = csr_wdata[CFG_MODE_BIT];
        end
        if (hit_en) r_d.en = csr_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFS_CMD: begin
                csr_rdata[CMD_OP_LSB +: 2]      = r_q.op;
                csr_rdata[CMD_PHY_LSB +: ADR_W] = r_q.phy;
                csr_rdata[CMD_DEV_LSB +: ADR_W] = r_q.dev;
            end
            OFS_WDAT: begin
                csr_rdata[DATA_W-1:0]  = r_q.wdat;
                csr_rdata[DAT_VAL_BIT]  = r_q.wval;
                csr_rdata[DAT_PEND_BIT] = r_q.wpend;
            end
            OFS_RDAT: begin
                csr_rdata[DATA_W-1:0]  = r_q.rdat;
                csr_rdata[DAT_VAL_BIT]  = r_q.rval;
                csr_rdata[DAT_PEND_BIT] = r_q.rpend;
            end
            OFS_CFG: begin
                csr_rdata[DIV_W-1:0]         = r_q.phase;
                csr_rdata[CFG_SMP_LSB +: 4]  = r_q.smp;
                csr_rdata[CFG_PRE_BIT]       = r_q.pre;
                csr_rdata[CFG_IDLE_BIT]      = r_q.idle;
                csr_rdata[CFG_SMOD_BIT]      = r_q.smode;
                csr_rdata[CFG_SHI_LSB +: 5]  = r_q.shi;
                csr_rdata[CFG_MODE_BIT]      = r_q.c45;
            end
            OFS_EN:  csr_rdata[0] = r_q.en;
            default: csr_rdata = '0;
        endcase
    end

    assign start_o     = accept;
    assign xact_o.st   = r_q.c45 ? 2'b00 : 2'b01;
    assign xact_o.op   = r_q.c45 ? cmd_op : (cmd_op[0] ? 2'b10 : 2'b01);
    assign xact_o.phy  = csr_wdata[CMD_PHY_LSB +: ADR_W];
    assign xact_o.dev  = csr_wdata[CMD_DEV_LSB +: ADR_W];
    assign xact_o.data = r_q.wdat;
    assign xact_o.rd   = is_rd;
    assign xact_o.pre  = r_q.pre;
    assign en_o        = r_q.en;
    assign idle_o      = r_q.idle;
    assign phase_o     = r_q.phase;

    // R8 / R9: completion only arrives for a frame that was marked pending
    a_r8_done_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (r_q.wpend || r_q.rpend));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    xact_t             xact;
    logic              start, busy, done, ta_ok, en, idle, run, rise, fall;
    logic [DATA_W-1:0] rdata;
    logic [DIV_W-1:0]  phase;

    assign run = busy && en;

    mdio_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .done_i    (done),
        .rdata_i   (rdata),
        .ta_ok_i   (ta_ok),
        .start_o   (start),
        .xact_o    (xact),
        .en_o      (en),
        .idle_o    (idle),
        .phase_o   (phase)
    );

    mdio_clkgen i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .idle_i  (idle),
        .phase_i (phase),
        .mdc_o   (mdc),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    mdio_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .xact_i    (xact),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .busy_o    (busy),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_o    (done),
        .rdata_o   (rdata),
        .ta_ok_o   (ta_ok)
    );

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // PHY model and wire monitor state
    logic        mon_clr = 1'b0;
    logic [15:0] phy_data = '0;
    logic        phy_ta = 1'b0;
    int          exp_hp = 2;
    logic        prev_mdc = 1'b0;
    logic [63:0] cap = '0;
    int          capn = 0;
    int          rcount = 0;
    int          hp_bad = 0;
    int          last_fall = 0;
    bit          have_fall = 0;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;

    assign mdio_i = phy_en ? phy_bit : 1'b1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_master i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(negedge clk) begin
        int n;
        if (mon_clr) begin
            cap <= '0; capn <= 0; rcount <= 0; have_fall <= 0; hp_bad <= 0;
            phy_en <= 1'b0; phy_bit <= 1'b1; prev_mdc <= mdc;
        end else begin
            prev_mdc <= mdc;
            if (prev_mdc && !mdc) begin
                if (mdio_oe) begin
                    cap  <= {cap[62:0], mdio_o};
                    capn <= capn + 1;
                    if (have_fall && ((cyc - last_fall) != exp_hp)) hp_bad <= hp_bad + 1;
                    last_fall <= cyc;
                    have_fall <= 1;
                end else begin
                    n = rcount + 1;
                    rcount <= n;
                    if (n == 2) begin
                        phy_en <= 1'b1; phy_bit <= phy_ta;
                    end else if (n >= 3 && n <= 18) begin
                        phy_en <= 1'b1; phy_bit <= phy_data[18-n];
                    end else begin
                        phy_en <= 1'b0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        #1 mon_clr = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        logic [63:0] a, b;
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(6'h08, a);
            rd(6'h10, b);
            if (!a[17] && !b[17]) begin ok = 1; break; end
        end
    endtask

    function automatic logic [1:0] wire_op(input logic c45, input logic [1:0] op);
        if (c45) return op;
        return (op == 2'd0) ? 2'b01 : 2'b10;
    endfunction

    // stimulus: mode, op, port, reg/dev, data, preamble, divider, TA bit from PHY, idle level
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 2'd0, 5'd5,  5'd3,  16'hA5C3, 1'b1, 8'd1, 1'b0, 1'b0},
        {1'b0, 2'd1, 5'd1,  5'd2,  16'h1234, 1'b0, 8'd0, 1'b0, 1'b1},
        {1'b1, 2'd0, 5'd3,  5'd1,  16'h8001, 1'b1, 8'd2, 1'b0, 1'b1},
        {1'b1, 2'd1, 5'd3,  5'd1,  16'hBEEF, 1'b0, 8'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 5'd31, 5'd31, 16'hF00F, 1'b0, 8'd1, 1'b0, 1'b0},
        {1'b0, 2'd1, 5'd7,  5'd4,  16'h5555, 1'b0, 8'd0, 1'b1, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [63:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd(6'h00, v); chk(v == 0, "R2 cmd reset", v, 0);
        rd(6'h08, v); chk(v == 0, "R2 wdat reset", v, 0);
        rd(6'h10, v); chk(v == 0, "R2 rdat reset", v, 0);
        rd(6'h18, v); chk(v == 0, "R2 cfg reset", v, 0);
        rd(6'h20, v); chk(v == 0, "R2 en reset", v, 0);
        chk(mdc == 0 && mdio_oe == 0, "R2 pins reset", {mdc, mdio_oe}, 0);

        // R1: field mask and unmapped offset
        wr(6'h18, '1);
        rd(6'h18, v); chk(v == 64'h11FBFFF, "R1 cfg mask", v, 64'h11FBFFF);
        wr(6'h20, '1);
        rd(6'h20, v); chk(v == 64'h1, "R1 en mask", v, 1);
        rd(6'h28, v); chk(v == 0, "R1 unmapped", v, 0);
        wr(6'h20, 64'h0);
        wr(6'h18, 64'h0);

        // main table
        for (int k = 0; k < NV; k++) begin
            logic        c45, pre, ta, idle, isrd;
            logic [1:0]  op;
            logic [4:0]  phy, dev;
            logic [15:0] dat;
            logic [7:0]  ph;
            logic [13:0] hdr;
            logic [63:0] full, mask;
            int          nb;
            string       tag;
            {c45, op, phy, dev, dat, pre, ph, ta, idle} = VEC[k];
            isrd = c45 ? (op == 2'd3) : (op == 2'd1);
            tag  = c45 ? "R6" : "R5";
            wr(6'h18, ({63'd0, c45} << 24) | ({63'd0, idle} << 13) | ({63'd0, pre} << 12) | {56'd0, ph});
            wr(6'h20, 64'h1);
            wr(6'h08, {48'd0, dat});
            phy_data = dat; phy_ta = ta; exp_hp = 2 * (int'(ph) + 1);
            clear_mon();
            chk(mdc == idle, "R4 idle level", {63'd0, mdc}, {63'd0, idle});
            wr(6'h00, ({62'd0, op} << 16) | ({59'd0, phy} << 8) | {59'd0, dev});
            rd(isrd ? 6'h10 : 6'h08, v);
            chk(v[17] == 1'b1, isrd ? "R9 pending" : "R8 pending", {63'd0, v[17]}, 1);
            wait_idle(ok);
            chk(ok, "R8 R9 completion", {63'd0, ok}, 1);
            hdr = {c45 ? 2'b00 : 2'b01, wire_op(c45, op), phy, dev};
            if (isrd) begin
                full = {18'd0, 32'hFFFF_FFFF, hdr};
                nb   = 14;
            end else begin
                full = {32'hFFFF_FFFF, hdr, 2'b10, dat};
                nb   = 32;
            end
            if (pre) nb += 32;
            mask = (nb == 64) ? '1 : ((64'd1 << nb) - 1);
            chk(capn == nb, "R7 driven bit count", capn, nb);
            chk((cap & mask) == (full & mask), tag, cap & mask, full & mask);
            chk(hp_bad == 0, "R4 bit spacing", hp_bad, 0);
            if (isrd) begin
                rd(6'h10, v);
                if (ta) chk(v[17:16] == 2'b00, "R10 invalid read", v, 0);
                else    chk(v == {46'd0, 2'b01, dat}, "R9 read data", v, {46'd0, 2'b01, dat});
            end else begin
                rd(6'h08, v);
                chk(v == {46'd0, 2'b01, dat}, "R8 write done", v, {46'd0, 2'b01, dat});
            end
        end

        // R3: disabled controller ignores command
        wr(6'h18, 64'h0);
        wr(6'h20, 64'h0);
        clear_mon();
        wr(6'h00, 64'h0000_0000_0000_0501);
        rd(6'h08, v); chk(v[17] == 0, "R3 no pending", v[17], 0);
        repeat (40) @(negedge clk);
        chk(capn == 0 && mdc == 0, "R3 mdc idle", capn, 0);

        // R11: command during pending is ignored
        wr(6'h20, 64'h1);
        wr(6'h08, 64'h0F0F);
        exp_hp = 2;
        clear_mon();
        wr(6'h00, 64'h0000_0000_0000_0503);
        wr(6'h00, 64'h0000_0000_0001_0902);
        rd(6'h10, v); chk(v[17] == 0, "R11 no read pending", v[17], 0);
        wait_idle(ok);
        repeat (60) @(negedge clk);
        chk(capn == 32, "R11 single frame", capn, 32);
        chk(cap[31:0] == {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'h0F0F}, "R11 frame intact",
            cap[31:0], {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'h0F0F});
        rd(6'h00, v); chk(v == 64'h0503, "R11 cmd kept", v, 64'h0503);

        // R12: undefined op codes
        clear_mon();
        wr(6'h00, 64'h0000_0000_0002_0101);
        rd(6'h08, v); chk(v[17] == 0, "R12 mode0 op2 wdat", v[17], 0);
        rd(6'h10, v); chk(v[17] == 0, "R12 mode0 op2 rdat", v[17], 0);
        wr(6'h00, 64'h0000_0000_0003_0101);
        rd(6'h10, v); chk(v[17] == 0, "R12 mode0 op3", v[17], 0);
        wr(6'h18, 64'h0100_0000);
        wr(6'h00, 64'h0000_0000_0002_0101);
        rd(6'h08, v); chk(v[17] == 0, "R12 mode1 op2", v[17], 0);
        repeat (40) @(negedge clk);
        chk(capn == 0, "R12 no frame", capn, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule